// File: doc/BRIEF.md
# Three-State Strap Lane Settings Controller

This block turns a handful of board straps, or a register bank written by a serial slave, into the control words of an eight-lane analog receive front end. For every lane it produces a 4-bit peaking code, a 2-bit flat-gain code, a 2-bit output-amplitude code and a power-down flag. Each strap arrives already resolved to one of three levels (low, open or high). The analog detection of those levels happens elsewhere.

A mode input chooses the source of the settings. In strap mode every lane receives the same decoded values. The peaking decode also depends on a channel-length strap. In register mode each lane takes its own register byte. The lanes are split into two banks, and a bank-select bit stands for the lower or upper serial address. The enable strap carries three meanings: power down, power up or hold in reset. Strap mode follows that strap continuously. Register mode only loads the power-down state from it when reset ends.

All outputs are registered, so a strap or mode change shows up one clock later and never glitches.

Top module: `strap_lane_ctrl`

## Requirements
- R1: In strap mode (ser_mode=0) all lanes carry the same peaking code, chosen by the peaking strap and the channel-length strap. A channel-length strap that is low or open selects the long channel: high gives 1110, open gives 1001 and low gives 0101. A channel-length strap that is high selects the short channel: high gives 1001, open gives 0101 and low gives 0010. Strap encoding: 00 is low, 01 is open, 10 is high, and 11 is treated as open.
- R2: In strap mode all lanes carry a flat-gain code of 00 when the gain strap is low, 01 when it is open and 10 when it is high.
- R3: In strap mode all lanes carry an amplitude code of 01 when the level strap is low, 10 when it is open and 11 when it is high.
- R4: In register mode (ser_mode=1) lane L takes its settings from the register at index L mod 4 in bank L/4 (wr_bank 0 holds lanes 0-3, wr_bank 1 holds lanes 4-7). Within that byte, bits [7:4] are the peaking code, bits [3:2] the flat-gain code and bits [1:0] the amplitude code.
- R5: In register mode, index 4 of a bank is the power-down register, and bit k of it drives the power-down flag of lane bank*4+k. A write to index 5, 6 or 7 changes no output.
- R6: In strap mode every lane is powered down (lane_pd=1) while the enable strap is high, and powered up while it is open.
- R7: In register mode the power-down flags of all lanes are loaded from the enable strap (high gives 1, open gives 0) on the first cycle after reset ends. A later change of the enable strap between high and open leaves them unchanged.
- R8: While the enable strap is low, every lane shows power-down with all codes zero and register writes are ignored. Once the strap is released, every lane register holds its default of 0x05 (peaking 0000, flat gain 01, amplitude 01).
- R9: rst=1 sets every output to power-down with all codes zero. Any strap change appears on the outputs exactly one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 0 = strap settings, 1 = register settings |
| peak_strap | input | 2 | Peaking strap level |
| flat_strap | input | 2 | Flat-gain strap level |
| level_strap | input | 2 | Output-amplitude strap level |
| app_strap | input | 2 | Channel-length strap level (high = short) |
| en_strap | input | 2 | Enable strap level (low = reset, open = on, high = off) |
| wr_en | input | 1 | Register write strobe from the serial slave |
| wr_bank | input | 1 | Bank select (0 = lower address, 1 = upper address) |
| wr_idx | input | 3 | Register index within the bank |
| wr_data | input | 8 | Register write data |
| lane_peak | output | 32 | Peaking code, 4 bits per lane, lane 0 in the low bits |
| lane_flat | output | 16 | Flat-gain code, 2 bits per lane |
| lane_amp | output | 16 | Amplitude code, 2 bits per lane |
| lane_pd | output | 8 | Power-down flag per lane |

## Verification
The bench builds the block with its default of eight lanes. That gives two banks of four lanes, so both halves of the lane-to-bank mapping and all four power-down bit positions in each bank are reached. With three-level straps, all nine combinations of peaking and channel-length straps fit in one directed sweep, and the reserved 11 strap encoding is covered as well. Four lanes per bank leave indices 5 to 7 unused, which allows writes to unused indices to be checked at the outputs.

// File: rtl/strap_lane_pkg.sv
package strap_lane_pkg;

    localparam int PEAK_W = 4;
    localparam int FG_W   = 2;
    localparam int AMP_W  = 2;
    localparam int CFG_W  = PEAK_W + FG_W + AMP_W;
    localparam int IDX_W  = 3;

    typedef enum logic [1:0] {
        TRI_LOW  = 2'b00,
        TRI_OPEN = 2'b01,
        TRI_HIGH = 2'b10
    } tri_t;

    typedef struct packed {
        logic [PEAK_W-1:0] peak;
        logic [FG_W-1:0]   fg;
        logic [AMP_W-1:0]  amp;
        logic              pd;
    } lane_ctrl_t;

    localparam lane_ctrl_t LANE_RESET = '{peak: '0, fg: '0, amp: '0, pd: 1'b1};
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'h05;

    // The unused code 11 is folded onto the open level.
    function automatic tri_t tri_norm(input logic [1:0] raw);
        case (raw)
            2'b00:   return TRI_LOW;
            2'b10:   return TRI_HIGH;
            default: return TRI_OPEN;
        endcase
    endfunction

    function automatic logic [PEAK_W-1:0] peak_decode(input tri_t lvl, input logic short_ch);
        logic [PEAK_W-1:0] code;
        if (short_ch) begin
            case (lvl)
                TRI_HIGH: code = 4'b1001;
                TRI_OPEN: code = 4'b0101;
                default:  code = 4'b0010;
            endcase
        end else begin
            case (lvl)
                TRI_HIGH: code = 4'b1110;
                TRI_OPEN: code = 4'b1001;
                default:  code = 4'b0101;
            endcase
        end
        return code;
    endfunction

    function automatic logic [FG_W-1:0] fg_decode(input tri_t lvl);
        case (lvl)
            TRI_HIGH: return 2'b10;
            TRI_OPEN: return 2'b01;
            default:  return 2'b00;
        endcase
    endfunction

    function automatic logic [AMP_W-1:0] amp_decode(input tri_t lvl);
        case (lvl)
            TRI_HIGH: return 2'b11;
            TRI_OPEN: return 2'b10;
            default:  return 2'b01;
        endcase
    endfunction

    function automatic lane_ctrl_t cfg_unpack(input logic [CFG_W-1:0] b, input logic pd);
        lane_ctrl_t r;
        r.peak = b[CFG_W-1 -: PEAK_W];
        r.fg   = b[AMP_W +: FG_W];
        r.amp  = b[AMP_W-1:0];
        r.pd   = pd;
        return r;
    endfunction

endpackage

// File: rtl/strap_decode.sv
module strap_decode
    import strap_lane_pkg::*;
(
    input  logic [1:0]  peak_strap,
    input  logic [1:0]  flat_strap,
    input  logic [1:0]  level_strap,
    input  logic [1:0]  app_strap,
    input  logic [1:0]  en_strap,
    output lane_ctrl_t  pin_ctrl
);

    tri_t app_lvl;

    always_comb begin
        app_lvl       = tri_norm(app_strap);
        pin_ctrl.peak = peak_decode(tri_norm(peak_strap), app_lvl == TRI_HIGH);
        pin_ctrl.fg   = fg_decode(tri_norm(flat_strap));
        pin_ctrl.amp  = amp_decode(tri_norm(level_strap));
        pin_ctrl.pd   = (tri_norm(en_strap) == TRI_HIGH);
    end

endmodule

// File: rtl/lane_cfg_bank.sv
module lane_cfg_bank
    import strap_lane_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             blocked,
    input  logic                             en_high,
    input  logic                             wr_en,
    input  logic                             wr_bank,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [CFG_W-1:0]                 wr_data,
    output logic [NUM_LANES-1:0][CFG_W-1:0]  cfg_q,
    output logic [NUM_LANES-1:0]             pd_q
);

    localparam int LPB    = NUM_LANES / 2;
    localparam int PD_IDX = LPB;

    logic                            fresh;
    logic [NUM_LANES-1:0][CFG_W-1:0] cfg_d;
    logic [NUM_LANES-1:0]            pd_d;

    always_comb begin
        cfg_d = cfg_q;
        pd_d  = pd_q;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (fresh) begin
                pd_d[l] = en_high;
            end else if (wr_en && (int'(wr_bank) == l / LPB)) begin
                if (int'(wr_idx) == l % LPB)
                    cfg_d[l] = wr_data;
                else if (int'(wr_idx) == PD_IDX)
                    pd_d[l] = wr_data[l % LPB];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || blocked) begin
            cfg_q <= {NUM_LANES{CFG_DEFAULT}};
            pd_q  <= '1;
            fresh <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
            pd_q  <= pd_d;
            fresh <= 1'b0;
        end
    end

    // R5
    bad_idx_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!blocked && wr_en && (int'(wr_idx) > PD_IDX)) |=> $stable(cfg_q));

    // R7
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!blocked && !fresh && !(wr_en && int'(wr_idx) == PD_IDX)) |=> $stable(pd_q));

endmodule

// File: rtl/lane_ctrl_out.sv
module lane_ctrl_out
    import strap_lane_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             hold,
    input  logic                             ser_mode,
    input  lane_ctrl_t                       pin_ctrl,
    input  logic [NUM_LANES-1:0][CFG_W-1:0]  cfg_q,
    input  logic [NUM_LANES-1:0]             pd_q,
    output lane_ctrl_t [NUM_LANES-1:0]       lane_q
);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lane_ctrl_t r;
        always_ff @(posedge clk) begin
            if (rst || hold)
                r <= LANE_RESET;
            else if (ser_mode)
                r <= cfg_unpack(cfg_q[l], pd_q[l]);
            else
                r <= pin_ctrl;
        end
        assign lane_q[l] = r;
    end

endmodule

// File: rtl/strap_lane_ctrl.sv
module strap_lane_ctrl
    import strap_lane_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ser_mode,
    input  logic [1:0]                    peak_strap,
    input  logic [1:0]                    flat_strap,
    input  logic [1:0]                    level_strap,
    input  logic [1:0]                    app_strap,
    input  logic [1:0]                    en_strap,
    input  logic                          wr_en,
    input  logic                          wr_bank,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [CFG_W-1:0]              wr_data,
    output logic [NUM_LANES*PEAK_W-1:0]   lane_peak,
    output logic [NUM_LANES*FG_W-1:0]     lane_flat,
    output logic [NUM_LANES*AMP_W-1:0]    lane_amp,
    output logic [NUM_LANES-1:0]          lane_pd
);

    tri_t                            en_lvl;
    logic                            en_low;
    lane_ctrl_t                      pin_ctrl;
    logic [NUM_LANES-1:0][CFG_W-1:0] cfg_q;
    logic [NUM_LANES-1:0]            pd_q;
    lane_ctrl_t [NUM_LANES-1:0]      lane_q;

    assign en_lvl = tri_norm(en_strap);
    assign en_low = (en_lvl == TRI_LOW);

    strap_decode u_dec (
        .peak_strap  (peak_strap),
        .flat_strap  (flat_strap),
        .level_strap (level_strap),
        .app_strap   (app_strap),
        .en_strap    (en_strap),
        .pin_ctrl    (pin_ctrl)
    );

    lane_cfg_bank #(.NUM_LANES(NUM_LANES)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .blocked (en_low),
        .en_high (en_lvl == TRI_HIGH),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .pd_q    (pd_q)
    );

    lane_ctrl_out #(.NUM_LANES(NUM_LANES)) u_out (
        .clk      (clk),
        .rst      (rst),
        .hold     (en_low),
        .ser_mode (ser_mode),
        .pin_ctrl (pin_ctrl),
        .cfg_q    (cfg_q),
        .pd_q     (pd_q),
        .lane_q   (lane_q)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_flat
        assign lane_peak[l*PEAK_W +: PEAK_W] = lane_q[l].peak;
        assign lane_flat[l*FG_W +: FG_W]     = lane_q[l].fg;
        assign lane_amp[l*AMP_W +: AMP_W]    = lane_q[l].amp;
        assign lane_pd[l]                    = lane_q[l].pd;
    end

    // R8
    en_low_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en_strap == 2'b00) |=> (lane_pd == '1 && lane_peak == '0));

    // R6
    pin_pd_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode && en_strap == 2'b10) |=> (lane_pd == '1));

    // R6
    pin_pd_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode && (en_strap == 2'b01 || en_strap == 2'b11)) |=> (lane_pd == '0));

endmodule

// File: tb/strap_lane_ctrl_tb.sv
module strap_lane_ctrl_tb;

    localparam int NL = 8;
    localparam logic [1:0] LO = 2'b00, OP = 2'b01, HI = 2'b10;

    logic clk = 1'b0;
    logic rst, ser_mode, wr_en, wr_bank;
    logic [1:0] peak_strap, flat_strap, level_strap, app_strap, en_strap;
    logic [2:0] wr_idx;
    logic [7:0] wr_data;
    logic [NL*4-1:0] lane_peak;
    logic [NL*2-1:0] lane_flat, lane_amp;
    logic [NL-1:0] lane_pd;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    strap_lane_ctrl #(.NUM_LANES(NL)) u_dut (
        .clk(clk), .rst(rst), .ser_mode(ser_mode),
        .peak_strap(peak_strap), .flat_strap(flat_strap), .level_strap(level_strap),
        .app_strap(app_strap), .en_strap(en_strap),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
        .lane_peak(lane_peak), .lane_flat(lane_flat), .lane_amp(lane_amp), .lane_pd(lane_pd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rep4(input logic [3:0] v);
        return {8{v}};
    endfunction

    function automatic logic [15:0] rep2(input logic [1:0] v);
        return {8{v}};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic bank, input logic [2:0] idx, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        chk("R9 reset pd", 32'(lane_pd), 32'hFF);
        chk("R9 reset peak", lane_peak, 32'h0);
        chk("R9 reset amp", 32'(lane_amp), 32'h0);
        rst = 1'b0;
        tick(3);
    endtask

    task automatic t_pin_peak();
        logic [1:0] apps[3] = '{LO, OP, HI};
        logic [1:0] pks[3]  = '{LO, OP, HI};
        logic [3:0] exp_long[3]  = '{4'b0101, 4'b1001, 4'b1110};
        logic [3:0] exp_short[3] = '{4'b0010, 4'b0101, 4'b1001};
        ser_mode = 1'b0;
        for (int a = 0; a < 3; a++) begin
            for (int p = 0; p < 3; p++) begin
                @(negedge clk);
                app_strap = apps[a]; peak_strap = pks[p];
                @(negedge clk);
                chk("R1 peak decode", lane_peak, rep4(a == 2 ? exp_short[p] : exp_long[p]));
            end
        end
        @(negedge clk);
        app_strap = 2'b11; peak_strap = 2'b11;
        @(negedge clk);
        chk("R1 code 11 as open", lane_peak, rep4(4'b1001));
    endtask

    task automatic t_pin_fg_amp();
        logic [1:0] lv[3]  = '{LO, OP, HI};
        logic [1:0] efg[3] = '{2'b00, 2'b01, 2'b10};
        logic [1:0] eam[3] = '{2'b01, 2'b10, 2'b11};
        ser_mode = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            flat_strap = lv[i]; level_strap = lv[2-i];
            @(negedge clk);
            chk("R2 flat gain decode", 32'(lane_flat), 32'(rep2(efg[i])));
            chk("R3 amplitude decode", 32'(lane_amp), 32'(rep2(eam[2-i])));
        end
    endtask

    task automatic t_pin_enable();
        ser_mode = 1'b0;
        @(negedge clk); en_strap = HI;
        @(negedge clk);
        chk("R6 pin enable high", 32'(lane_pd), 32'hFF);
        @(negedge clk); en_strap = OP;
        @(negedge clk);
        chk("R6 pin enable open", 32'(lane_pd), 32'h00);
    endtask

    task automatic t_timing();
        ser_mode = 1'b0; app_strap = LO;
        @(negedge clk); peak_strap = LO;
        @(negedge clk); peak_strap = HI;
        #2;
        chk("R9 no change before edge", lane_peak, rep4(4'b0101));
        @(negedge clk);
        chk("R9 change after one edge", lane_peak, rep4(4'b1110));
    endtask

    task automatic t_serial_lanes();
        ser_mode = 1'b1;
        for (int l = 0; l < NL; l++)
            reg_wr(1'(l / 4), 3'(l % 4), 8'((l + 1) * 16 + l * 4 + 3 - (l % 4)));
        tick(1);
        for (int l = 0; l < NL; l++) begin
            logic [7:0] b = 8'((l + 1) * 16 + l * 4 + 3 - (l % 4));
            chk("R4 lane peak", 32'(lane_peak[l*4 +: 4]), 32'(b[7:4]));
            chk("R4 lane flat", 32'(lane_flat[l*2 +: 2]), 32'(b[3:2]));
            chk("R4 lane amp", 32'(lane_amp[l*2 +: 2]), 32'(b[1:0]));
        end
    endtask

    task automatic t_serial_pd();
        logic [31:0] pk_before;
        ser_mode = 1'b1;
        reg_wr(1'b0, 3'd4, 8'h05);
        reg_wr(1'b1, 3'd4, 8'h0A);
        tick(1);
        chk("R5 pd register map", 32'(lane_pd), 32'hA5);
        pk_before = lane_peak;
        reg_wr(1'b0, 3'd5, 8'hFF);
        reg_wr(1'b1, 3'd7, 8'h00);
        tick(2);
        chk("R5 unused index peak", lane_peak, pk_before);
        chk("R5 unused index pd", 32'(lane_pd), 32'hA5);
    endtask

    task automatic t_serial_enable();
        ser_mode = 1'b1; en_strap = HI;
        rst = 1'b1; tick(2); rst = 1'b0;
        tick(3);
        chk("R7 pd loaded high", 32'(lane_pd), 32'hFF);
        en_strap = OP; tick(3);
        chk("R7 enable change ignored", 32'(lane_pd), 32'hFF);
        reg_wr(1'b0, 3'd4, 8'h00);
        reg_wr(1'b1, 3'd4, 8'h00);
        tick(1);
        chk("R7 pd written", 32'(lane_pd), 32'h00);
        en_strap = HI; tick(3);
        chk("R7 enable high ignored", 32'(lane_pd), 32'h00);
        en_strap = OP;
        rst = 1'b1; tick(2); rst = 1'b0;
        tick(3);
        chk("R7 pd loaded open", 32'(lane_pd), 32'h00);
    endtask

    task automatic t_enable_reset();
        ser_mode = 1'b1; en_strap = OP;
        reg_wr(1'b0, 3'd2, 8'hFA);
        @(negedge clk); en_strap = LO;
        @(negedge clk);
        chk("R8 enable low pd", 32'(lane_pd), 32'hFF);
        chk("R8 enable low peak", lane_peak, 32'h0);
        reg_wr(1'b1, 3'd1, 8'hFF);
        ser_mode = 1'b0; tick(1);
        chk("R8 enable low pin mode", 32'(lane_pd), 32'hFF);
        ser_mode = 1'b1;
        en_strap = OP; tick(4);
        chk("R8 default peak", lane_peak, 32'h0);
        chk("R8 default flat", 32'(lane_flat), 32'(rep2(2'b01)));
        chk("R8 default amp", 32'(lane_amp), 32'(rep2(2'b01)));
        chk("R8 pd after release", 32'(lane_pd), 32'h00);
    endtask

    initial begin
        rst = 1'b1; ser_mode = 1'b0; wr_en = 1'b0; wr_bank = 1'b0;
        wr_idx = '0; wr_data = '0;
        peak_strap = OP; flat_strap = OP; level_strap = OP; app_strap = LO; en_strap = OP;
        t_reset();
        t_pin_peak();
        t_pin_fg_amp();
        t_pin_enable();
        t_timing();
        t_serial_lanes();
        t_serial_pd();
        t_serial_enable();
        t_enable_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule